// File: doc/BRIEF.md
# Converter Bring-Up and Serial Configuration Sequencer

This block sits on the host side of a serially configured data converter. It takes the converter from power-up to a programmed state. When a start pulse reports that the supplies are stable, the block first waits out a minimum power-on delay. It then holds the converter's reset line high for a minimum width and waits a minimum recovery gap after reset is released. Only then does it open a single select-low window and shift its whole configuration list out.

Each configuration word is 16 bits: a 4-bit register address in bits 15:12 and a 12-bit value in bits 11:0. Bits are sent most significant first. The serial clock idles high. Data moves on its rising edge, so that the line is steady when the converter samples it on the falling edge. All three delays come from a clock-frequency parameter and are rounded up to whole cycles, so each one is a guaranteed minimum. When the last word has gone out, the block raises `done` and stays there until a new start pulse runs the whole sequence again.

Top module: `conv_bringup_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, and until the first accepted start, the outputs rest at `conv_reset`=0, `cfg_cs_n`=1, `cfg_sclk`=1, `cfg_mosi`=0 and `done`=0. A reset in the middle of a sequence returns the outputs to these values at the next edge.
- R2: A start pulse is accepted when the block is idle. `conv_reset` rises exactly PWR_CYC = ceil(CLK_HZ·PWR_ON_NS/1e9) cycles after the edge that accepted the start.
- R3: `conv_reset` then stays high for exactly RST_CYC = ceil(CLK_HZ·RST_NS/1e9) cycles.
- R4: `cfg_cs_n` falls exactly GAP_CYC = ceil(CLK_HZ·GAP_NS/1e9) cycles after `conv_reset` falls. `conv_reset` and a low `cfg_cs_n` never coincide.
- R5: `cfg_sclk` is high whenever `cfg_cs_n` is high. Inside the window, every bit lasts SCLK_DIV cycles: SCLK_DIV/2 cycles high, then SCLK_DIV/2 cycles low.
- R6: `cfg_mosi` changes only when `cfg_cs_n` falls or `cfg_sclk` rises. It is therefore steady over each falling edge and through the whole low half.
- R7: Words leave in list order, word i taken from CFG_WORDS[16·i+15:16·i]. Each word is sent MSB first (address bits 15:12, then data bits 11:0), one bit per falling edge, 16 per word, with no gap between words.
- R8: The window lasts exactly NUM_WORDS·16·SCLK_DIV cycles. `cfg_cs_n` returns high SCLK_DIV/2 cycles after the last falling edge, and `done` rises on the same cycle.
- R9: A start pulse that arrives during the wait, reset, gap or shift phases has no effect on any output.
- R10: A start pulse while `done` is high clears `done` and repeats the whole sequence from the power-on delay. Without such a pulse, `done` stays high.
- R11: Each delay rounds a fractional cycle count up. For example, 2 µs at 1.25 MHz gives 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, frequency CLK_HZ |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Supplies-up / restart request, sampled on the clock edge |
| conv_reset | output | 1 | Active-high reset to the converter |
| cfg_cs_n | output | 1 | Serial select, active low |
| cfg_sclk | output | 1 | Serial clock, idles high |
| cfg_mosi | output | 1 | Serial data to the converter |
| done | output | 1 | Configuration finished |

## Verification
Every result follows from the edge that accepted the start: the reset rise is due PWR_CYC edges after it, the reset fall RST_CYC edges later, the select fall GAP_CYC edges after that, and each serial bit occupies a fixed SCLK_DIV-cycle slot. The bench's reference model counts edges since acceptance, using only these formulas. At every falling clock edge, half a period after the registers settle, it compares all five outputs with the values due in that cycle. Ignored start pulses, the restart from done and a reset in mid-window are applied at chosen model counts, so every later cycle checks that the timeline did or did not shift.

// File: rtl/cbs_pkg.sv
// Package: shared state encoding and elaboration-time helpers for the
// converter bring-up sequencer.
// Assumes: frequencies in Hz, delays in ns, products fit in 64 bits.
package cbs_pkg;

    localparam int WORD_W    = 16;
    localparam int MAX_WORDS = 16;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_PWR_WAIT  = 3'd1,
        ST_RST_PULSE = 3'd2,
        ST_RST_GAP   = 3'd3,
        ST_SHIFT     = 3'd4,
        ST_DONE      = 3'd5
    } seq_state_t;

    // Whole clock cycles covering at least ns nanoseconds (rounded up, min 1).
    function automatic int ns_to_cycles(longint hz, longint ns);
        longint prod;
        longint cyc;
        prod = hz * ns;
        cyc  = (prod + 64'd999_999_999) / 64'd1_000_000_000;
        if (cyc < 1) cyc = 1;
        return int'(cyc);
    endfunction

    // Build one configuration word from a register address and a value.
    function automatic logic [WORD_W-1:0] pack_word(logic [3:0] addr, logic [11:0] value);
        return {addr, value};
    endfunction

endpackage

// File: rtl/cbs_delay_timer.sv
// Module: single up-counter shared by all timed phases of the sequencer.
// expired pulses on the last cycle of a phase lasting `limit` cycles.
// Assumes: limit >= 1; restart is raised on every phase change.
module cbs_delay_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    // Count cycles spent in the current timed phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || !run) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // Terminal count reached: this is the phase's last cycle.
    always_comb begin
        expired = run && (cnt == (limit - CNT_W'(1)));
    end

endmodule

// File: rtl/cbs_sclk_gen.sv
// Module: serial clock phase counter. Each bit slot is DIV system cycles:
// first half high, second half low. Clock idles high when not running.
// Assumes: DIV is even and at least 2.
module cbs_sclk_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic bit_end
);

    localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int HALF = DIV / 2;

    logic [PH_W-1:0] ph;

    // Phase position within the current bit slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= '0;
        end else if (!run) begin
            ph <= '0;
        end else if (ph == PH_W'(DIV - 1)) begin
            ph <= '0;
        end else begin
            ph <= ph + PH_W'(1);
        end
    end

    // Clock level and end-of-slot strobe decoded from the phase.
    always_comb begin
        sclk    = !(run && (ph >= PH_W'(HALF)));
        bit_end = run && (ph == PH_W'(DIV - 1));
    end

endmodule

// File: rtl/cbs_word_shifter.sv
// Module: holds the configuration list and shifts it out MSB first,
// word after word without gaps.
// Assumes: load and advance never coincide; 1 <= NUM_WORDS <= MAX_WORDS.
module cbs_word_shifter
    import cbs_pkg::*;
#(
    parameter int                            NUM_WORDS = 4,
    parameter logic [MAX_WORDS*WORD_W-1:0]   CFG_WORDS = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic advance,
    output logic data_bit,
    output logic last_bit
);

    localparam int WI_W  = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int TBL_N = 1 << WI_W;
    localparam int BC_W  = $clog2(WORD_W);

    logic [WORD_W-1:0] tbl [TBL_N];
    logic [WORD_W-1:0] sreg;
    logic [BC_W-1:0]   bc;
    logic [WI_W-1:0]   wi;
    logic [WI_W-1:0]   wi_next;
    logic              word_end;

    // Word table from the parameter; unused slots read as zero.
    for (genvar g = 0; g < TBL_N; g++) begin : g_tbl
        if (g < NUM_WORDS) begin : g_used
            assign tbl[g] = CFG_WORDS[WORD_W*g +: WORD_W];
        end else begin : g_pad
            assign tbl[g] = '0;
        end
    end

    // Position decode for the word and bit counters.
    always_comb begin
        wi_next  = wi + WI_W'(1);
        word_end = (bc == BC_W'(WORD_W - 1));
        last_bit = word_end && (wi == WI_W'(NUM_WORDS - 1));
        data_bit = sreg[WORD_W-1];
    end

    // Load the first word, then shift or fetch the next on each slot end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
            bc   <= '0;
            wi   <= '0;
        end else if (load) begin
            sreg <= tbl[0];
            bc   <= '0;
            wi   <= '0;
        end else if (advance) begin
            if (word_end) begin
                if (!last_bit) begin
                    sreg <= tbl[wi_next];
                    wi   <= wi_next;
                    bc   <= '0;
                end
            end else begin
                sreg <= {sreg[WORD_W-2:0], 1'b0};
                bc   <= bc + BC_W'(1);
            end
        end
    end

endmodule

// File: rtl/conv_bringup_seq.sv
// Module: top of the converter bring-up sequencer. Phase controller that
// runs power-on wait, reset pulse, recovery gap and one serial burst.
// Assumes: SCLK_DIV even >= 2; NUM_WORDS in 1..16; start is synchronous.
module conv_bringup_seq
    import cbs_pkg::*;
#(
    parameter longint                        CLK_HZ    = 100_000_000,
    parameter longint                        PWR_ON_NS = 10_000_000,
    parameter longint                        RST_NS    = 2_000,
    parameter longint                        GAP_NS    = 2_000,
    parameter int                            SCLK_DIV  = 4,
    parameter int                            NUM_WORDS = 4,
    parameter logic [MAX_WORDS*WORD_W-1:0]   CFG_WORDS = {
        {(MAX_WORDS-4)*WORD_W{1'b0}},
        16'h3_0A0, 16'h2_155, 16'h1_800, 16'h0_001 }
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic conv_reset,
    output logic cfg_cs_n,
    output logic cfg_sclk,
    output logic cfg_mosi,
    output logic done
);

    localparam int PWR_CYC = ns_to_cycles(CLK_HZ, PWR_ON_NS);
    localparam int RST_CYC = ns_to_cycles(CLK_HZ, RST_NS);
    localparam int GAP_CYC = ns_to_cycles(CLK_HZ, GAP_NS);
    localparam int MAX_A   = (PWR_CYC > RST_CYC) ? PWR_CYC : RST_CYC;
    localparam int MAX_CYC = (MAX_A > GAP_CYC) ? MAX_A : GAP_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    seq_state_t       st, st_nx;
    logic [CNT_W-1:0] limit;
    logic             timed;
    logic             expired;
    logic             shifting;
    logic             sclk_i;
    logic             bit_end;
    logic             data_bit;
    logic             last_bit;
    logic             load_first;

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // Phase transitions.
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:      if (start)               st_nx = ST_PWR_WAIT;
            ST_PWR_WAIT:  if (expired)             st_nx = ST_RST_PULSE;
            ST_RST_PULSE: if (expired)             st_nx = ST_RST_GAP;
            ST_RST_GAP:   if (expired)             st_nx = ST_SHIFT;
            ST_SHIFT:     if (bit_end && last_bit) st_nx = ST_DONE;
            ST_DONE:      if (start)               st_nx = ST_PWR_WAIT;
            default:                               st_nx = ST_IDLE;
        endcase
    end

    // Terminal count for the phase being timed.
    always_comb begin
        timed = 1'b1;
        case (st)
            ST_PWR_WAIT:  limit = CNT_W'(PWR_CYC);
            ST_RST_PULSE: limit = CNT_W'(RST_CYC);
            ST_RST_GAP:   limit = CNT_W'(GAP_CYC);
            default: begin
                limit = CNT_W'(1);
                timed = 1'b0;
            end
        endcase
    end

    cbs_delay_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (timed),
        .restart (st_nx != st),
        .limit   (limit),
        .expired (expired)
    );

    // Serial burst controls.
    always_comb begin
        shifting   = (st == ST_SHIFT);
        load_first = (st == ST_RST_GAP) && expired;
    end

    cbs_sclk_gen #(
        .DIV (SCLK_DIV)
    ) u_sclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (shifting),
        .sclk    (sclk_i),
        .bit_end (bit_end)
    );

    cbs_word_shifter #(
        .NUM_WORDS (NUM_WORDS),
        .CFG_WORDS (CFG_WORDS)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_first),
        .advance  (bit_end),
        .data_bit (data_bit),
        .last_bit (last_bit)
    );

    // Output decode from registered phase and shifter state.
    always_comb begin
        conv_reset = (st == ST_RST_PULSE);
        cfg_cs_n   = !shifting;
        cfg_sclk   = sclk_i;
        cfg_mosi   = shifting && data_bit;
        done       = (st == ST_DONE);
    end

endmodule

// File: rtl/cbs_checker.sv
// Module: temporal properties of the sequencer's pins, bound to the top.
// Assumes: MIN_RST and MIN_GAP are the rounded-up cycle counts.
module cbs_checker #(
    parameter int MIN_RST = 1,
    parameter int MIN_GAP = 1
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic conv_reset,
    input logic cfg_cs_n,
    input logic cfg_sclk,
    input logic cfg_mosi,
    input logic done
);

    logic [15:0] hi_cnt;
    logic [15:0] gap_cnt;

    // Length of the current reset pulse and of the quiet time after it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt  <= '0;
            gap_cnt <= '0;
        end else begin
            if (conv_reset) hi_cnt <= (hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 16'd1;
            else            hi_cnt <= '0;
            if (conv_reset)                       gap_cnt <= '0;
            else if (cfg_cs_n && gap_cnt != 16'hFFFF) gap_cnt <= gap_cnt + 16'd1;
        end
    end

    p_rst_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_reset) |-> (hi_cnt >= 16'(MIN_RST)));

    p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_reset |-> cfg_cs_n);

    p_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_cs_n) |-> (gap_cnt >= 16'(MIN_GAP)));

    p_sclk_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_cs_n |-> cfg_sclk);

    p_mosi_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_cs_n && !cfg_sclk && $past(!cfg_cs_n)) |-> $stable(cfg_mosi));

    p_done_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $rose(cfg_cs_n));

    p_done_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

endmodule

bind conv_bringup_seq cbs_checker #(
    .MIN_RST (RST_CYC),
    .MIN_GAP (GAP_CYC)
) u_cbs_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .conv_reset (conv_reset),
    .cfg_cs_n   (cfg_cs_n),
    .cfg_sclk   (cfg_sclk),
    .cfg_mosi   (cfg_mosi),
    .done       (done)
);

// File: tb/tb_conv_bringup_seq.sv
// Bench: edge-counting reference model compared with all outputs each cycle.
module tb_conv_bringup_seq;

    localparam int     CLK_PERIOD = 10;
    localparam longint T_HZ       = 1_250_000;
    localparam int     T_DIV      = 4;
    localparam int     T_NW       = 3;
    localparam int     HALF       = T_DIV / 2;
    // Expected counts from R2, R3, R4 and R11: 10 ms and 2 us at 1.25 MHz.
    localparam int     P_EXP      = 12500;
    localparam int     R_EXP      = 3;     // 2.5 rounded up (R11)
    localparam int     G_EXP      = 3;     // 2.5 rounded up (R11)
    localparam int     S0         = P_EXP + R_EXP + G_EXP;
    localparam int     TOTAL      = S0 + T_NW * 16 * T_DIV;
    localparam int     WDOG       = 100_000;
    localparam logic [15:0] W0 = 16'h1A5C;
    localparam logic [15:0] W1 = 16'h70F3;
    localparam logic [15:0] W2 = 16'hE801;

    logic clk = 1'b0;
    logic rst_n;
    logic start;
    logic conv_reset, cfg_cs_n, cfg_sclk, cfg_mosi, done;

    int    checks = 0;
    int    fails  = 0;
    int    el     = -1;
    int    cyc    = 0;
    bit    armed  = 0;
    bit    ended  = 0;
    string scen   = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    conv_bringup_seq #(
        .CLK_HZ    (T_HZ),
        .SCLK_DIV  (T_DIV),
        .NUM_WORDS (T_NW),
        .CFG_WORDS ({208'd0, W2, W1, W0})
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .conv_reset (conv_reset),
        .cfg_cs_n   (cfg_cs_n),
        .cfg_sclk   (cfg_sclk),
        .cfg_mosi   (cfg_mosi),
        .done       (done)
    );

    function automatic logic [15:0] word_at(int i);
        case (i)
            0:       return W0;
            1:       return W1;
            default: return W2;
        endcase
    endfunction

    task automatic finish_sim();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic chk(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s (%s) %s at model count %0d: actual %b expected %b",
                     tag, scen, what, el, act, exp);
        end
    endtask

    // Reference timeline: edges counted since the accepted start.
    always @(posedge clk) begin
        armed <= 1;
        cyc   <= cyc + 1;
        if (!rst_n)                            el <= -1;
        else if ((el < 0 || el >= TOTAL) && start) el <= 0;   // R2 accept, R10 restart
        else if (el >= 0 && el < TOTAL)        el <= el + 1;  // R9: start ignored here
    end

    // Watchdog: an overrun counts as a failure and still reports.
    always @(posedge clk) begin
        if (cyc > WDOG && !ended) begin
            checks++;
            fails++;
            $display("FAIL watchdog (%s): actual %0d cycles expected at most %0d", scen, cyc, WDOG);
            finish_sim();
        end
    end

    // Compare every output half a period after each rising edge.
    always @(negedge clk) begin
        if (armed && !ended) begin
            logic e_rst, e_cs, e_sclk, e_mosi, e_done;
            int   j, ph;
            bit   in_win;
            in_win = (el >= S0) && (el < TOTAL);
            j      = el - S0;
            ph     = in_win ? (j % T_DIV) : 0;
            e_rst  = (el >= P_EXP) && (el < P_EXP + R_EXP);
            e_cs   = !in_win;
            e_sclk = in_win ? (ph < HALF) : 1'b1;
            e_mosi = in_win ? word_at(j / (16 * T_DIV))[15 - (j / T_DIV) % 16] : 1'b0;
            e_done = (el >= TOTAL);
            if (el < 0) begin
                chk("R1", "conv_reset", conv_reset, 1'b0);
                chk("R1", "cfg_cs_n",   cfg_cs_n,   1'b1);
                chk("R1", "cfg_sclk",   cfg_sclk,   1'b1);
                chk("R1", "cfg_mosi",   cfg_mosi,   1'b0);
                chk("R1", "done",       done,       1'b0);
            end else begin
                chk((el < P_EXP) ? "R2" : "R3", "conv_reset", conv_reset, e_rst);
                chk((el <= S0) ? "R4" : "R8", "cfg_cs_n", cfg_cs_n, e_cs);
                chk("R5", "cfg_sclk", cfg_sclk, e_sclk);
                chk((in_win && ph >= HALF) ? "R6" : "R7", "cfg_mosi", cfg_mosi, e_mosi);
                chk((el >= TOTAL) ? "R8" : "R10", "done", done, e_done);
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_el(int target);
        while (el != target) @(negedge clk);
    endtask

    initial begin
        start = 1'b0;
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        scen = "R1";
        repeat (10) @(negedge clk);
        // First run: rounded-up timing (R11, R2, R3, R4).
        scen = "R11";
        pulse_start();
        wait_el(200);
        // Start during the power-on wait must not move anything (R9).
        scen = "R9";
        pulse_start();
        wait_el(S0 + 50);
        pulse_start();
        wait_el(TOTAL);
        repeat (20) @(negedge clk);
        // Restart from done (R10).
        scen = "R10";
        pulse_start();
        wait_el(S0 + 30);
        // Reset in the middle of the window (R1).
        scen = "R1";
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        // Full run after reset, through to done (R7, R8).
        scen = "R7";
        pulse_start();
        wait_el(TOTAL);
        repeat (10) @(negedge clk);
        finish_sim();
    end

endmodule